// File: doc/BRIEF.md
# I2C Slave Engine with Software-Paced Handshake

This block is the slave half of a two-wire serial port for a small processor. Software programs a 7-bit station address and a general-call enable, then turns the engine on through a five-bit control word. The engine watches the synchronised SCL and SDA lines, detects START and STOP, and shifts in the address byte. When the address is its own (or the general-call address, if allowed), it acknowledges and then receives or transmits data bytes.

Every completed bus step ends with a hardware-set interrupt flag and a status code. While the flag is up the engine holds SCL low, so the remote master waits for as long as software needs. Software reads the status, loads or collects data and sets the acknowledge choice for the next byte. Clearing the flag lets the bus move on. The acknowledge bit picks ACK or NACK for received bytes. When it is clear, the engine also ignores every address, which takes the device off the bus.

Top module: `i2c_slave_hs`

## Requirements
- R1: After reset the status reads F8h, the address register reads FEh, the control word reads 0, the interrupt output is low and neither SCL nor SDA is driven.
- R2: Control word bits are enable [4], start request [3], stop request [2], interrupt flag [1] and acknowledge [0]. The address register holds the station address in [7:1] and the general-call enable in [0]. With enable and acknowledge set, an address byte whose upper seven bits equal the station address is acknowledged by SDA low in the ninth clock. After that clock falls, the flag rises with status 60h when bit 0 of the byte is 0 (write) and A8h when it is 1 (read).
- R3: With the general-call enable set, a byte of 00h is acknowledged and raises status 70h. With it clear, 00h gets no acknowledge and no flag. Any other non-matching address is ignored in the same way.
- R4: With the acknowledge bit clear, no address is recognised: SDA stays high in the ninth clock and the flag stays low. Setting the bit again restores recognition.
- R5: While the flag is set the engine pulls SCL low, and it releases SCL once software clears the flag. The flag is set only by hardware. It is cleared by writing the control word with bit [1] at 0, and writing 1 there never sets it.
- R6: A data byte received while addressed appears on rx_byte. With the acknowledge bit set it is acknowledged, with status 80h (own address) or 90h (general call). With the bit clear it gets a NACK, with status 88h or 98h. The engine then ignores further bytes until a new START.
- R7: After a read address, the byte software loads into the transmit register is sent MSB first, starting once the flag is cleared. An ACK from the master gives status B8h and a NACK gives C0h, after which the engine releases the bus.
- R8: A STOP or repeated START seen while addressed raises the flag with status A0h and does not hold SCL. When the engine is not addressed it raises no flag.
- R9: The three low status bits are always 0, and the status reads F8h whenever the flag is clear.
- R10: The stop request bit clears itself when a STOP occurs on the bus. The start request bit keeps its value until software writes it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 5 | Control word write data |
| adr_wr | input | 1 | Write strobe for the address register |
| adr_wdata | input | 8 | Address register write data |
| dat_wr | input | 1 | Write strobe for the transmit register |
| dat_wdata | input | 8 | Transmit byte |
| ctl_rd | output | 5 | Control word read value |
| stat_rd | output | 8 | Status code |
| adr_rd | output | 8 | Address register read value |
| rx_byte | output | 8 | Last received data byte |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest states to reach are the ones that depend on the order in which software and the master act. One is a clock held low by the flag while the master has already released SCL. Another is a repeated START or STOP arriving while the engine is still addressed. A third is a NACKed byte followed by bytes that must be ignored. The bench models an open-drain bus. It pauses the bit-level master exactly after the ninth clock falls, clears the flag from a software task, and in one directed bit releases SCL before the flag is cleared to observe the hold. Seeded random transactions vary the station address, general-call enable, acknowledge choice, target address, direction and byte count. Each response is checked against bench-computed expectations.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CODE_W = BYTE_W - 3;
  localparam int CTL_W  = 5;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t C_OWN_W   = code_t'(8'h60 >> 3);
  localparam code_t C_GEN     = code_t'(8'h70 >> 3);
  localparam code_t C_RX_OWN  = code_t'(8'h80 >> 3);
  localparam code_t C_RX_OWNN = code_t'(8'h88 >> 3);
  localparam code_t C_RX_GEN  = code_t'(8'h90 >> 3);
  localparam code_t C_RX_GENN = code_t'(8'h98 >> 3);
  localparam code_t C_END     = code_t'(8'hA0 >> 3);
  localparam code_t C_OWN_R   = code_t'(8'hA8 >> 3);
  localparam code_t C_TX_ACK  = code_t'(8'hB8 >> 3);
  localparam code_t C_TX_NACK = code_t'(8'hC0 >> 3);
  localparam code_t C_IDLE    = code_t'(8'hF8 >> 3);

  localparam logic [BYTE_W-1:0] ADR_RESET = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
  } eng_state_t;

  typedef struct packed {
    logic en;
    logic sta;
    logic sto;
    logic flag;
    logic ack;
  } ctl_t;

  function automatic logic [BYTE_W-1:0] code_to_byte(input code_t c);
    return {c, 3'b000};
  endfunction

  function automatic logic addr_match(input logic [BYTE_W-1:0] rx,
                                      input logic [ADDR_W-1:0] own,
                                      input logic gc_en,
                                      input logic ack_en);
    logic own_hit, gen_hit;
    own_hit = (rx[BYTE_W-1:1] == own);
    gen_hit = gc_en && (rx[BYTE_W-1:1] == '0) && !rx[0];
    return ack_en && (own_hit || gen_hit);
  endfunction

  function automatic code_t rx_done_code(input logic gen, input logic acked);
    if (gen) return acked ? C_RX_GEN : C_RX_GENN;
    return acked ? C_RX_OWN : C_RX_OWNN;
  endfunction
endpackage

// File: rtl/i2c_hs_sync.sv
module i2c_hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES:0] scl_c, sda_c;
  logic scl_d, sda_d, scl_s;

  assign scl_c[0] = scl_i;
  assign sda_c[0] = sda_i;

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_c[g] <= 1'b1;
        sda_c[g] <= 1'b1;
      end else begin
        scl_c[g] <= scl_c[g-1];
        sda_c[g] <= sda_c[g-1];
      end
    end
  end

  assign scl_s = scl_c[STAGES];
  assign sda_s = sda_c[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s && !scl_d;
  assign scl_fall  = !scl_s && scl_d;
  assign start_evt = scl_s && scl_d && sda_d && !sda_s;
  assign stop_evt  = scl_s && scl_d && !sda_d && sda_s;
endmodule

// File: rtl/i2c_hs_regs.sv
module i2c_hs_regs
  import i2c_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              adr_wr,
  input  logic [BYTE_W-1:0] adr_wdata,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              flag_set,
  input  logic              stop_evt,
  output ctl_t              ctl,
  output logic [BYTE_W-1:0] adr,
  output logic [BYTE_W-1:0] txd,
  output logic              flag_clr
);
  ctl_t wr_ctl;
  assign wr_ctl   = ctl_t'(ctl_wdata);
  assign flag_clr = ctl_wr && !wr_ctl.flag && ctl.flag && !flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      adr <= ADR_RESET;
      txd <= '0;
    end else begin
      if (ctl_wr) begin
        ctl.en   <= wr_ctl.en;
        ctl.sta  <= wr_ctl.sta;
        ctl.sto  <= wr_ctl.sto;
        ctl.ack  <= wr_ctl.ack;
        ctl.flag <= ctl.flag && wr_ctl.flag;
      end
      if (stop_evt) ctl.sto  <= 1'b0;
      if (flag_set) ctl.flag <= 1'b1;
      if (adr_wr) adr <= adr_wdata;
      if (dat_wr) txd <= dat_wdata;
    end
  end
endmodule

// File: rtl/i2c_hs_engine.sv
module i2c_hs_engine
  import i2c_hs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ack_bit,
  input  logic              flag,
  input  logic              flag_clr,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] own_adr,
  input  logic [BYTE_W-1:0] txd,
  output logic              flag_set,
  output code_t             code,
  output logic              stretch,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              hit_evt
);
  eng_state_t        state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic              is_gen, rw, ackdrv, got_ack, addressed;
  logic              bus_evt, last_rx_fall, slot_fall;

  assign bus_evt      = start_evt || stop_evt;
  assign last_rx_fall = scl_fall && (cnt == 4'd8);
  assign slot_fall    = scl_fall && (cnt == 4'd1);
  assign hit_evt      = en && !bus_evt && (state == ST_ADDR) && last_rx_fall &&
                        addr_match(shreg, own_adr[BYTE_W-1:1], own_adr[0], ack_bit);

  always_comb begin
    case (state)
      ST_AACK: sda_oe = 1'b1;
      ST_RACK: sda_oe = ackdrv;
      ST_TX:   sda_oe = !flag && !shreg[BYTE_W-1];
      default: sda_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      is_gen    <= 1'b0;
      rw        <= 1'b0;
      ackdrv    <= 1'b0;
      got_ack   <= 1'b0;
      addressed <= 1'b0;
      flag_set  <= 1'b0;
      code      <= C_IDLE;
      stretch   <= 1'b0;
      rx_byte   <= '0;
    end else begin
      flag_set <= 1'b0;
      if (!en) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        addressed <= 1'b0;
      end else if (bus_evt) begin
        if (addressed) begin
          flag_set  <= 1'b1;
          code      <= C_END;
          stretch   <= 1'b0;
          addressed <= 1'b0;
        end
        state <= start_evt ? ST_ADDR : ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_ADDR, ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (last_rx_fall) begin
              cnt <= '0;
              if (state == ST_RX) begin
                rx_byte <= shreg;
                ackdrv  <= ack_bit;
                state   <= ST_RACK;
              end else if (hit_evt) begin
                is_gen <= (shreg[BYTE_W-1:1] != own_adr[BYTE_W-1:1]);
                rw     <= shreg[0];
                state  <= ST_AACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_RACK, ST_TACK: begin
            if (scl_rise) begin
              cnt <= 4'd1;
              if (state == ST_TACK) got_ack <= !sda_s;
            end else if (slot_fall) begin
              cnt      <= '0;
              flag_set <= 1'b1;
              stretch  <= 1'b1;
              if (state == ST_AACK) begin
                code      <= rw ? C_OWN_R : (is_gen ? C_GEN : C_OWN_W);
                addressed <= 1'b1;
                state     <= rw ? ST_TX : ST_RX;
              end else if (state == ST_RACK) begin
                code      <= rx_done_code(is_gen, ackdrv);
                addressed <= ackdrv;
                state     <= ackdrv ? ST_RX : ST_IDLE;
              end else begin
                code      <= got_ack ? C_TX_ACK : C_TX_NACK;
                addressed <= got_ack;
                state     <= got_ack ? ST_TX : ST_IDLE;
              end
            end
          end
          ST_TX: begin
            if (flag_clr) begin
              shreg <= txd;
              cnt   <= '0;
            end else if (scl_fall) begin
              if (cnt == 4'd7) begin
                cnt   <= '0;
                state <= ST_TACK;
              end else begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                cnt   <= cnt + 4'd1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_hs.sv
module i2c_slave_hs
  import i2c_hs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              adr_wr,
  input  logic [BYTE_W-1:0] adr_wdata,
  input  logic              dat_wr,
  input  logic [BYTE_W-1:0] dat_wdata,
  output logic [CTL_W-1:0]  ctl_rd,
  output logic [BYTE_W-1:0] stat_rd,
  output logic [BYTE_W-1:0] adr_rd,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              irq
);
  logic  sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic  flag_set, flag_clr, stretch, hit_evt;
  ctl_t  ctl;
  code_t code;
  logic [BYTE_W-1:0] txd;

  i2c_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_hs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .adr_wr(adr_wr), .adr_wdata(adr_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .flag_set(flag_set), .stop_evt(stop_evt), .ctl(ctl), .adr(adr_rd),
    .txd(txd), .flag_clr(flag_clr)
  );

  i2c_hs_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .ack_bit(ctl.ack), .flag(ctl.flag),
    .flag_clr(flag_clr), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .own_adr(adr_rd), .txd(txd),
    .flag_set(flag_set), .code(code), .stretch(stretch), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .hit_evt(hit_evt)
  );

  assign ctl_rd  = ctl;
  assign irq     = ctl.flag;
  assign scl_oe  = ctl.flag && stretch;
  assign stat_rd = ctl.flag ? code_to_byte(code) : code_to_byte(C_IDLE);
endmodule

// File: rtl/i2c_slave_hs_chk.sv
module i2c_slave_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic [7:0] stat_rd,
  input logic       flag_set,
  input logic       ctl_wr,
  input logic [4:0] ctl_wdata,
  input logic       hit_evt,
  input logic [4:0] ctl_rd,
  input logic       stop_evt
);
  p_low_bits_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd[2:0] == 3'b000);

  p_idle_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> stat_rd == 8'hF8);

  p_hold_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> irq);

  p_flag_hw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flag_set));

  p_flag_sw_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(ctl_wr && !ctl_wdata[1]));

  p_hit_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> ctl_rd[0] && ctl_rd[4]);

  p_stop_clears_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !ctl_rd[2]);

  p_end_no_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && stat_rd == 8'hA0) |-> !scl_oe);
endmodule

bind i2c_slave_hs i2c_slave_hs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .stat_rd(stat_rd),
  .flag_set(flag_set), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .hit_evt(hit_evt), .ctl_rd(ctl_rd), .stop_evt(stop_evt)
);

// File: tb/sim_i2c_slave_hs.sv
module sim_i2c_slave_hs;
  localparam int Q = 12;
  localparam logic [4:0] EN = 5'h10, STA = 5'h08, STO = 5'h04, FLG = 5'h02, ACK = 5'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic ctl_wr = 1'b0, adr_wr = 1'b0, dat_wr = 1'b0;
  logic [4:0] ctl_wdata = '0, ctl_rd;
  logic [7:0] adr_wdata = '0, dat_wdata = '0, stat_rd, adr_rd, rx_byte;
  logic irq;
  int nvec = 0, nbad = 0;

  always #4 clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_slave_hs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .adr_wr(adr_wr), .adr_wdata(adr_wdata), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .ctl_rd(ctl_rd), .stat_rd(stat_rd), .adr_rd(adr_rd), .rx_byte(rx_byte), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_hit(input logic [7:0] b, input logic [6:0] own,
                                   input logic gc, input logic ack);
    if (!ack) return 1'b0;
    if (b[7:1] == own) return 1'b1;
    return gc && (b == 8'h00);
  endfunction

  function automatic logic [7:0] exp_rx(input logic gen, input logic acked);
    logic [7:0] v;
    v = gen ? 8'h90 : 8'h80;
    if (!acked) v = v + 8'h08;
    return v;
  endfunction

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; q();
    scl_up(); q();
    m_sda_low = 1'b1; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; q();
    scl_up(); q();
    m_sda_low = 1'b0; q();
  endtask

  task automatic m_wbit(input logic b);
    m_sda_low = !b; q();
    scl_up(); q(); q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic m_rbit(output logic b);
    m_sda_low = 1'b0; q();
    scl_up(); q();
    b = sda_line; q();
    m_scl_low = 1'b1; q();
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ackv);
    for (int i = 7; i >= 0; i--) m_wbit(v[i]);
    m_rbit(ackv);
  endtask

  task automatic m_rbyte(output logic [7:0] v, input logic nack);
    for (int i = 7; i >= 0; i--) m_rbit(v[i]);
    m_wbit(nack);
  endtask

  task automatic sw_ctl(input logic [4:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic sw_adr(input logic [7:0] v);
    @(negedge clk); adr_wr = 1'b1; adr_wdata = v;
    @(negedge clk); adr_wr = 1'b0;
  endtask

  task automatic sw_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_wdata = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    int unsigned seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", stat_rd, 8'hF8);
    chk("R1 address", adr_rd, 8'hFE);
    chk("R1 control", ctl_rd, 5'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 drives", {scl_oe, sda_oe}, 2'b00);

    // R5 writing 1 to the flag bit does not set it
    sw_ctl(EN | ACK | FLG);
    chk("R5 sw cannot set flag", irq, 1'b0);
    chk("R9 idle status", stat_rd, 8'hF8);

    // R2 own address write, with a directed stretch check
    sw_adr({7'h2A, 1'b0});
    m_start();
    m_wbyte({7'h2A, 1'b0}, a);
    chk("R2 addr ack", a, 1'b0);
    chk("R2 flag", irq, 1'b1);
    chk("R2 status 60", stat_rd, 8'h60);
    chk("R5 scl held", scl_oe, 1'b1);
    m_sda_low = 1'b0; q();
    m_scl_low = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 scl line low while flag", scl_line, 1'b0);
    sw_ctl(EN | ACK);
    chk("R5 flag cleared", irq, 1'b0);
    chk("R5 scl released", scl_line, 1'b1);
    chk("R9 status after clear", stat_rd, 8'hF8);
    q(); q();
    m_scl_low = 1'b1; q();
    for (int i = 6; i >= 0; i--) m_wbit(1'(8'hC3 >> i));
    m_rbit(a);
    chk("R6 data ack", a, 1'b0);
    chk("R6 status 80", stat_rd, 8'h80);
    chk("R6 rx byte", rx_byte, 8'hC3);
    // R6 NACK path, then following bytes ignored
    sw_ctl(EN);
    m_wbyte(8'h5A, a);
    chk("R6 data nack", a, 1'b1);
    chk("R6 status 88", stat_rd, 8'h88);
    chk("R6 rx byte 2", rx_byte, 8'h5A);
    sw_ctl(EN | ACK);
    m_wbyte(8'h11, a);
    chk("R6 ignored after nack", a, 1'b1);
    chk("R6 no flag after nack", irq, 1'b0);
    chk("R6 rx unchanged", rx_byte, 8'h5A);
    m_stop(); q();
    chk("R8 no end flag when unaddressed", irq, 1'b0);

    // R8 STOP while addressed, R10 request bits
    m_start();
    m_wbyte({7'h2A, 1'b0}, a);
    sw_ctl(EN | ACK);
    m_wbyte(8'h0F, a);
    sw_ctl(EN | ACK | STA | STO);
    m_stop(); q();
    chk("R8 stop flag", irq, 1'b1);
    chk("R8 status A0", stat_rd, 8'hA0);
    chk("R8 no hold", scl_oe, 1'b0);
    chk("R10 stop req cleared", ctl_rd[2], 1'b0);
    chk("R10 start req kept", ctl_rd[3], 1'b1);
    sw_ctl(EN | ACK);
    chk("R10 start req cleared by sw", ctl_rd[3], 1'b0);

    // R8 repeated START then R2/R7 read
    m_start();
    m_wbyte({7'h2A, 1'b0}, a);
    sw_ctl(EN | ACK);
    m_start(); 
    chk("R8 restart flag", stat_rd, 8'hA0);
    sw_ctl(EN | ACK);
    m_wbyte({7'h2A, 1'b1}, a);
    chk("R2 read addr ack", a, 1'b0);
    chk("R2 status A8", stat_rd, 8'hA8);
    sw_dat(8'hA5);
    sw_ctl(EN | ACK);
    m_rbyte(d, 1'b0);
    chk("R7 tx byte 1", d, 8'hA5);
    chk("R7 status B8", stat_rd, 8'hB8);
    sw_dat(8'h3C);
    sw_ctl(EN | ACK);
    m_rbyte(d, 1'b1);
    chk("R7 tx byte 2", d, 8'h3C);
    chk("R7 status C0", stat_rd, 8'hC0);
    sw_ctl(EN | ACK);
    m_stop(); q();
    chk("R7 released after nack", {irq, sda_oe}, 2'b00);

    // R3 general call
    sw_adr({7'h2A, 1'b1});
    m_start();
    m_wbyte(8'h00, a);
    chk("R3 gc ack", a, 1'b0);
    chk("R3 status 70", stat_rd, 8'h70);
    sw_ctl(EN | ACK);
    m_wbyte(8'h77, a);
    chk("R3 gc data 90", stat_rd, 8'h90);
    sw_ctl(EN);
    m_wbyte(8'h78, a);
    chk("R6 gc data 98", stat_rd, 8'h98);
    sw_ctl(EN | ACK);
    m_stop();
    sw_adr({7'h2A, 1'b0});
    m_start();
    m_wbyte(8'h00, a);
    chk("R3 gc disabled nack", a, 1'b1);
    chk("R3 gc disabled no flag", irq, 1'b0);
    m_stop();
    m_start();
    m_wbyte({7'h15, 1'b0}, a);
    chk("R3 other addr ignored", {a, irq}, 2'b10);
    m_stop();

    // R4 acknowledge bit off takes the device off the bus
    sw_ctl(EN);
    m_start();
    m_wbyte({7'h2A, 1'b0}, a);
    chk("R4 off bus nack", a, 1'b1);
    chk("R4 off bus no flag", irq, 1'b0);
    m_stop();
    sw_ctl(EN | ACK);
    m_start();
    m_wbyte({7'h2A, 1'b0}, a);
    chk("R4 resumed ack", a, 1'b0);
    chk("R4 resumed status", stat_rd, 8'h60);
    sw_ctl(EN | ACK);
    m_stop(); q();
    sw_ctl(EN | ACK);

    // random transactions
    for (int t = 0; t < 24; t++) begin
      logic [6:0] own;
      logic gc, ak, rw, hit, last;
      logic [7:0] tgt, v;
      int nb;
      own = 7'($urandom_range(1, 127));
      gc  = 1'($urandom);
      ak  = ($urandom_range(0, 3) != 0);
      rw  = 1'($urandom);
      case ($urandom_range(0, 2))
        0: tgt = {own, rw};
        1: tgt = {7'h00, rw};
        default: tgt = {7'($urandom), rw};
      endcase
      nb = $urandom_range(1, 3);
      sw_adr({own, gc});
      sw_ctl(EN | (ak ? ACK : 5'h00));
      hit = exp_hit(tgt, own, gc, ak);
      m_start();
      m_wbyte(tgt, a);
      chk("R2 rnd addr ack", a, !hit);
      chk("R3 rnd flag", irq, hit);
      if (hit) begin
        if (rw) chk("R2 rnd A8", stat_rd, 8'hA8);
        else chk("R3 rnd 60/70", stat_rd, (tgt[7:1] == own) ? 8'h60 : 8'h70);
        for (int k = 0; k < nb; k++) begin
          v = 8'($urandom);
          last = (k == nb - 1);
          if (rw) begin
            sw_dat(v);
            sw_ctl(EN | ACK);
            m_rbyte(d, last);
            chk("R7 rnd tx data", d, v);
            chk("R7 rnd status", stat_rd, last ? 8'hC0 : 8'hB8);
          end else begin
            sw_ctl(EN | ACK);
            m_wbyte(v, a);
            chk("R6 rnd rx data", rx_byte, v);
            chk("R6 rnd status", stat_rd, exp_rx(tgt[7:1] != own, 1'b1));
          end
        end
        sw_ctl(EN | ACK);
      end
      m_stop(); q();
      chk("R8 rnd end flag", irq, hit && !rw);
      if (irq) sw_ctl(EN | ACK);
    end

    finish_run();
  end
endmodule